// File: doc/BRIEF.md
# Frame Transfer Handshake Sequencer

This block is the control sequencer between an image capture front end and an external compression processor. It does not carry pixels itself. It starts capture, asks the processor to drain the outbound FIFO, and then pulls the compressed result back out of the return FIFO, one frame at a time. The outbound FIFO is watched through its fill level. When that level reaches half full, the sequencer issues a single-cycle DMA request.

The processor signals that it has finished compressing with a completion interrupt, and only that event moves the sequencer into readback. Readback is a valid/ready stream. The return FIFO presents a word with `rb_valid_i`, and the sequencer takes it with the read strobe `rb_ready_o`. The sequencer forwards each word downstream on `out_valid_o` / `out_ready_i`. When the downstream side holds `out_ready_i` low, no word is read from the return FIFO, and the word stays in place until it is accepted. The read strobe is never raised while the return FIFO is empty.

The sequencer counts the words of each frame. On the last word it inspects the frame's validity flag. A good frame sends it back to capture for the next frame. A bad frame produces a one-cycle stop notification to the processor and sends the sequencer back to idle.

Top module: `frame_xfer_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces idle, clears the word counter and any pending request, and re-arms the half-full detector. From the next edge on, `acq_en_o`, `dma_req_o`, `rb_ready_o`, `out_valid_o`, `out_last_o` and `stop_o` are all 0.
- R2: In idle, `start_i` sampled high at an edge raises `acq_en_o` from that edge on. In every other phase, `start_i` has no effect.
- R3: While capturing, if `ob_level_i >= HALF` is sampled at an edge and the detector is armed, `dma_req_o` is high for exactly the following cycle.
- R4: After a request, the detector stays disarmed until `ob_level_i < HALF` is sampled at some edge, in any phase. A level that stays at or above `HALF` therefore yields one request only.
- R5: `irq_done_i` sampled high during capture ends capture: from that edge `acq_en_o` is 0 and readback begins. The interrupt is ignored in idle and during readback.
- R6: The read strobe `rb_ready_o` equals readback AND `rb_valid_i` AND `out_ready_i`. It is never high while the return FIFO is empty.
- R7: During readback, `out_valid_o` follows `rb_valid_i` and `out_data_o` equals `rb_data_i`. Outside readback, `out_valid_o` is 0.
- R8: The word counter advances only on cycles with `rb_ready_o` high. `out_last_o` is high during readback while the counter holds word index FRAME_WORDS-1, with words numbered from 0.
- R9: If `rb_ok_i` is 1 when the last word is read, capture resumes from the next edge (`acq_en_o` = 1).
- R10: If `rb_ok_i` is 0 when the last word is read, `stop_o` is high for exactly the next cycle, after which the sequencer is idle and waits for `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Acquisition command |
| ob_level_i | input | LVL_W | Fill level of the outbound FIFO |
| irq_done_i | input | 1 | Completion interrupt from the processor |
| rb_valid_i | input | 1 | Return FIFO not empty |
| rb_data_i | input | DATA_W | Return FIFO head word |
| rb_ok_i | input | 1 | Frame validity flag, sampled with the last word |
| out_ready_i | input | 1 | Downstream accepts a word |
| acq_en_o | output | 1 | Capture enable |
| dma_req_o | output | 1 | Single-cycle DMA request to the processor |
| rb_ready_o | output | 1 | Read strobe to the return FIFO |
| out_valid_o | output | 1 | Downstream word valid |
| out_data_o | output | DATA_W | Downstream word |
| out_last_o | output | 1 | Current word is the last of the frame |
| stop_o | output | 1 | One-cycle end notification to the processor |

## Verification
The bench holds the fill level above half for many cycles and then dips it below and back. A detector that re-fires on level instead of on a crossing would emit a burst of requests, and one that never re-arms would go silent after the first. It fires interrupts and start commands in the wrong phases, which a loosely decoded state machine would act on. It toggles downstream back-pressure and FIFO emptiness across frame boundaries, where a counter that advances on `rb_valid_i` alone would end the frame early and a missing empty gate would strobe an empty FIFO. It also mixes good and bad frames, so a flipped validity decision either stops on a good frame or loops forever on a bad one.

// File: rtl/fxs_pkg.sv
package fxs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_READ = 2'd2,
    ST_STOP = 2'd3
  } fxs_state_t;
endpackage

// File: rtl/fxs_half_trig.sv
// Half-full crossing detector: one request per upward crossing while enabled.
module fxs_half_trig #(
  parameter int LVL_W = 5,
  parameter int HALF  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [LVL_W-1:0] level,
  output logic             req_o
);
  localparam logic [LVL_W-1:0] THR = LVL_W'(HALF);

  logic armed_q;
  logic req_q;
  logic hit;

  assign hit = (level >= THR);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b1;
      req_q   <= 1'b0;
    end else begin
      req_q <= en && armed_q && hit;
      if (!hit)
        armed_q <= 1'b1;
      else if (en && armed_q)
        armed_q <= 1'b0;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/fxs_word_ctr.sv
// Per-frame word counter; advances only on accepted reads.
module fxs_word_ctr #(
  parameter int FRAME_WORDS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic last_o
);
  localparam int CNT_W = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_WORDS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (adv)
      cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST_IDX);
endmodule

// File: rtl/fxs_ctrl.sv
// Phase sequencer: idle -> capture -> readback -> capture / stop -> idle.
module fxs_ctrl
  import fxs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       irq,
  input  logic       xfer,
  input  logic       last,
  input  logic       ok,
  output fxs_state_t state_o
);
  fxs_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_CAPT;
      ST_CAPT: if (irq)   st_d = ST_READ;
      ST_READ: if (xfer && last) st_d = ok ? ST_CAPT : ST_STOP;
      ST_STOP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/frame_xfer_seq.sv
module frame_xfer_seq
  import fxs_pkg::*;
#(
  parameter int LVL_W       = 5,
  parameter int HALF        = 16,
  parameter int DATA_W      = 16,
  parameter int FRAME_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [LVL_W-1:0]  ob_level_i,
  input  logic              irq_done_i,
  input  logic              rb_valid_i,
  input  logic [DATA_W-1:0] rb_data_i,
  input  logic              rb_ok_i,
  input  logic              out_ready_i,
  output logic              acq_en_o,
  output logic              dma_req_o,
  output logic              rb_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o,
  output logic              stop_o
);
  fxs_state_t state;
  logic       in_read;
  logic       xfer;
  logic       last;

  assign in_read = (state == ST_READ);
  assign xfer    = in_read && rb_valid_i && out_ready_i;

  fxs_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start_i),
    .irq     (irq_done_i),
    .xfer    (xfer),
    .last    (last),
    .ok      (rb_ok_i),
    .state_o (state)
  );

  fxs_half_trig #(.LVL_W(LVL_W), .HALF(HALF)) u_trig (
    .clk   (clk),
    .rst   (rst),
    .en    (state == ST_CAPT),
    .level (ob_level_i),
    .req_o (dma_req_o)
  );

  fxs_word_ctr #(.FRAME_WORDS(FRAME_WORDS)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .adv    (xfer),
    .last_o (last)
  );

  assign acq_en_o    = (state == ST_CAPT);
  assign rb_ready_o  = xfer;
  assign out_valid_o = in_read && rb_valid_i;
  assign out_data_o  = rb_data_i;
  assign out_last_o  = in_read && last;
  assign stop_o      = (state == ST_STOP);
endmodule

// File: rtl/fxs_chk.sv
module fxs_chk #(
  parameter int LVL_W = 5,
  parameter int HALF  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] ob_level_i,
  input logic             rb_valid_i,
  input logic             out_ready_i,
  input logic             acq_en_o,
  input logic             dma_req_o,
  input logic             rb_ready_o,
  input logic             out_valid_o,
  input logic             stop_o
);
  // R3
  dma_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req_o |=> !dma_req_o);

  // R4
  dma_needs_half_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req_o |-> ($past(ob_level_i) >= LVL_W'(HALF)));

  // R6
  no_empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    rb_ready_o |-> (rb_valid_i && out_ready_i));

  // R5
  phase_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(acq_en_o && out_valid_o));

  // R10
  stop_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_o |=> (!stop_o && !acq_en_o));
endmodule

bind frame_xfer_seq fxs_chk #(.LVL_W(LVL_W), .HALF(HALF)) u_fxs_chk (
  .clk         (clk),
  .rst         (rst),
  .ob_level_i  (ob_level_i),
  .rb_valid_i  (rb_valid_i),
  .out_ready_i (out_ready_i),
  .acq_en_o    (acq_en_o),
  .dma_req_o   (dma_req_o),
  .rb_ready_o  (rb_ready_o),
  .out_valid_o (out_valid_o),
  .stop_o      (stop_o)
);

// File: tb/test_frame_xfer_seq.sv
`timescale 1ns/1ps
module test_frame_xfer_seq;
  localparam int LVL_W = 5;
  localparam int HALF  = 16;
  localparam int DW    = 16;
  localparam int FW    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, irq_done_i = 1'b0, rb_valid_i = 1'b0, rb_ok_i = 1'b1, out_ready_i = 1'b0;
  logic [LVL_W-1:0] ob_level_i = '0;
  logic [DW-1:0] rb_data_i = '0;
  logic acq_en_o, dma_req_o, rb_ready_o, out_valid_o, out_last_o, stop_o;
  logic [DW-1:0] out_data_o;

  always #2.5 clk = ~clk;

  frame_xfer_seq #(.LVL_W(LVL_W), .HALF(HALF), .DATA_W(DW), .FRAME_WORDS(FW)) i_frame_xfer_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .ob_level_i(ob_level_i),
    .irq_done_i(irq_done_i), .rb_valid_i(rb_valid_i), .rb_data_i(rb_data_i),
    .rb_ok_i(rb_ok_i), .out_ready_i(out_ready_i), .acq_en_o(acq_en_o),
    .dma_req_o(dma_req_o), .rb_ready_o(rb_ready_o), .out_valid_o(out_valid_o),
    .out_data_o(out_data_o), .out_last_o(out_last_o), .stop_o(stop_o));

  int n_chk = 0, n_fail = 0;
  int n_req = 0, n_stop = 0;
  bit live = 0, done = 0;

  // behavioural reference: phase 0 idle, 1 capture, 2 read, 3 stop
  int m_ph = 0, m_cnt = 0;
  bit m_armed = 1, m_req = 0;
  int fifo[$];

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit hit, xf;
    hit = (ob_level_i >= HALF);
    xf  = (m_ph == 2) && rb_valid_i && out_ready_i;
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_armed = 1; m_req = 0;
    end else begin
      m_req = (m_ph == 1) && m_armed && hit;
      if (!hit) m_armed = 1;
      else if (m_ph == 1 && m_armed) m_armed = 0;
      case (m_ph)
        0: if (start_i) m_ph = 1;
        1: if (irq_done_i) m_ph = 2;
        2: if (xf && m_cnt == FW-1) m_ph = rb_ok_i ? 1 : 3;
        default: m_ph = 0;
      endcase
      if (xf) m_cnt = (m_cnt == FW-1) ? 0 : m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      check("R2 acq_en", acq_en_o, m_ph == 1);
      check("R3 dma_req", dma_req_o, m_req);
      check("R6 rb_ready", rb_ready_o, (m_ph == 2) && rb_valid_i && out_ready_i);
      check("R7 out_valid", out_valid_o, (m_ph == 2) && rb_valid_i);
      if (out_valid_o) check("R7 out_data", out_data_o, rb_data_i);
      check("R8 out_last", out_last_o, (m_ph == 2) && (m_cnt == FW-1));
      check("R10 stop", stop_o, m_ph == 3);
      n_req  += dma_req_o;
      n_stop += stop_o;
    end
  end

  // return FIFO model: head word presented, popped on read strobe
  always @(posedge clk) if (rb_ready_o && fifo.size() > 0) void'(fifo.pop_front());

  task automatic cyc(input bit st, input int lvl, input bit irq, input bit vld,
                     input bit rdy, input bit ok);
    start_i = st; ob_level_i = LVL_W'(lvl); irq_done_i = irq;
    if (fifo.size() == 0) fifo.push_back(int'($urandom_range(0, 65535)));
    rb_valid_i = vld; rb_data_i = DW'(fifo[0]); out_ready_i = rdy; rb_ok_i = ok;
    @(posedge clk); #1;
  endtask

  initial begin
    int r0, s0;
    repeat (3) @(posedge clk);
    #1;
    cyc(0, 0, 0, 0, 0, 1);
    rst = 0;
    live = 1;
    // R1 reset state
    check("R1 acq_en", acq_en_o, 0);
    check("R1 dma_req", dma_req_o, 0);
    check("R1 stop", stop_o, 0);
    check("R1 rb_ready", rb_ready_o, 0);
    // R5 interrupt in idle ignored, R6 nothing read in idle
    cyc(0, 20, 1, 1, 1, 1);
    check("R5 irq idle", acq_en_o, 0);
    check("R6 idle read", rb_ready_o, 0);
    check("R3 no req idle", dma_req_o, 0);
    // R2 start enters capture; level high and armed -> single request (R3, R4)
    r0 = n_req;
    cyc(1, 20, 0, 0, 0, 1);
    check("R2 capture", acq_en_o, 1);
    for (int i = 0; i < 10; i++) cyc(0, 20, 0, 0, 0, 1);
    check("R4 one req", n_req - r0, 1);
    cyc(0, 15, 0, 0, 0, 1);
    cyc(0, 16, 0, 0, 0, 1);
    cyc(0, 17, 0, 0, 0, 1);
    check("R4 rearm", n_req - r0, 2);
    // R5 interrupt -> readback
    cyc(0, 3, 1, 0, 0, 1);
    check("R5 leave capture", acq_en_o, 0);
    // R8 back-pressure and empty: no advance
    cyc(0, 3, 1, 1, 0, 1);
    check("R6 held", rb_ready_o, 0);
    cyc(0, 3, 0, 0, 1, 1);
    for (int i = 0; i < FW; i++) cyc(0, 3, 0, 1, 1, 1);
    check("R9 resume capture", acq_en_o, 1);
    // second frame invalid -> stop (R10)
    s0 = n_stop;
    cyc(0, 3, 1, 0, 0, 0);
    for (int i = 0; i < FW; i++) cyc(0, 3, 0, 1, 1, 0);
    check("R10 stop pulse", stop_o, 1);
    cyc(0, 3, 1, 0, 0, 0);
    check("R10 idle", acq_en_o, 0);
    check("R10 one stop", n_stop - s0, 1);
    cyc(0, 3, 1, 0, 0, 0);
    check("R10 waits start", acq_en_o, 0);
    // randomised phase
    begin
      int lvl = 10;
      for (int i = 0; i < 4000; i++) begin
        lvl += int'($urandom_range(0, 4)) - 2;
        if (lvl < 0) lvl = 0;
        if (lvl > 31) lvl = 31;
        if (i == 2500) begin rst = 1; cyc(0, lvl, 0, 1, 1, 1); rst = 0; end
        cyc($urandom_range(0, 7) == 0, lvl, $urandom_range(0, 15) == 0,
            $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
            $urandom_range(0, 3) != 0);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule